// File: doc/BRIEF.md
# Six-Source Prioritized Vectored Interrupt Controller

This controller collects interrupt requests from six sources and names one of them to a processor core. Four sources are asynchronous external lines. Each line crosses two synchronizing flops, and the request bit is captured on the rising edge of the synchronized level. The other two sources are single-cycle pulses from on-chip timers that are already synchronous. Requests are held in a six-bit pending register. Software may load that register directly to raise software interrupts, or read it to poll when vectoring is off.

A per-source enable mask and a global enable decide whether the processor is interrupted. A priority word sets the order among three source pairs. Group A is sources 0 and 1, group B is sources 2 and 3, and group C is the two timer sources 4 and 5. The controller presents the index of the winning source. When the core acknowledges, the controller clears that source's pending bit and the global enable in the same cycle, so the handler runs with interrupts off until software enables them again.

The pending register stays at zero and ignores every input until the first global-enable command after reset. This keeps stale requests from firing before the software has configured the controller.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset `req_q` is 00h, `gie` is 0, `irq_out` is 0 and `vec_id` is 0.
- R2: Until the first `gie_set` pulse after reset, `req_q` stays 00h. Register writes, external rises and timer pulses are all ignored during that time.
- R3: Once armed, a low-to-high change on `ext_req[n]` that is driven before clock edge k sets `req_q[n]` at edge k+2 and not earlier. A line that stays high sets its bit only once.
- R4: Once armed, a one-cycle pulse on `tmr_req[m]` sets `req_q[4+m]` at the next edge.
- R5: Once armed, a write with `wr_sel`=0 loads `wr_data[5:0]` into the pending register. Request sets that arrive in the same cycle are ORed on top.
- R6: A write with `wr_sel`=1 loads the per-source enables from `wr_data[5:0]` and the global enable from `wr_data[7]`. `irq_out` is high exactly when `gie` is 1 and some bit of (pending AND enables) is 1.
- R7: `gie_set` sets `gie` to 1 and `gie_clr` clears it to 0. When both are high in the same cycle, `gie_clr` wins.
- R8: A write with `wr_sel`=2 loads the priority word from `wr_data[5:0]`. Its field [2:0] sets the group order, from highest to lowest: 1=A,B,C; 2=A,C,B; 3=B,A,C; 4=B,C,A; 5=C,A,B; 6=C,B,A. `vec_id` names the highest enabled pending source.
- R9: Priority bits 3, 4 and 5 swap the order inside group A, B and C respectively. When a swap bit is 0 the lower-numbered source of its pair wins. When it is 1 the higher-numbered source wins.
- R10: The order codes 0 and 7 act exactly like code 1 (A,B,C).
- R11: When `ack` is high while `irq_out` is high, the next edge clears `req_q[vec_id]` and `gie`. When `ack` is high while `irq_out` is low, it changes nothing.
- R12: With `gie` at 0, `req_q` still shows the pending requests for polling, and `irq_out` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_req | input | 4 | Asynchronous external request lines, sources 0 to 3 |
| tmr_req | input | 2 | Synchronous timer request pulses, sources 4 and 5 |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 pending, 1 mask, 2 priority, 3 none |
| wr_data | input | 8 | Write data |
| gie_set | input | 1 | Global-enable command; the first one arms the pending register |
| gie_clr | input | 1 | Global-disable command |
| ack | input | 1 | Interrupt acknowledge from the core |
| req_q | output | 6 | Pending request register |
| gie | output | 1 | Global enable state |
| irq_out | output | 1 | Interrupt request to the core |
| vec_id | output | 3 | Index of the winning source |

## Verification
Writes, timer pulses, enable commands and acknowledges are each registered once, so their results appear one edge after the stimulus. `irq_out` and `vec_id` are combinational on the registers and follow in that same cycle. An external line needs three edges: two synchronizer stages and the edge capture. The bench therefore checks that the pending bit is still clear after two edges and set after the third. All inputs are driven on the falling clock edge, and every output is sampled on the falling edge after the edge that is meant to update it. Priority results are compared against a model of the order and swap rules, run over many pending patterns and all 64 priority words.

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl #(
  parameter int N_EXT = 4,
  parameter int N_TMR = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_EXT-1:0]       ext_req,
  input  logic [N_TMR-1:0]       tmr_req,
  input  logic                   wr_en,
  input  logic [1:0]             wr_sel,
  input  logic [7:0]             wr_data,
  input  logic                   gie_set,
  input  logic                   gie_clr,
  input  logic                   ack,
  output logic [N_EXT+N_TMR-1:0] req_q,
  output logic                   gie,
  output logic                   irq_out,
  output logic [2:0]             vec_id
);
  localparam int NSRC = N_EXT + N_TMR;
  localparam int NGRP = NSRC / 2;

  logic [N_EXT-1:0] s1, s2, s2_d;
  logic [NSRC-1:0]  en;
  logic [5:0]       prio;
  logic             armed;

  wire [N_EXT-1:0] ext_rise = s2 & ~s2_d;
  wire [NSRC-1:0]  pend     = req_q & en;
  wire             served   = irq_out & ack;
  wire [NSRC-1:0]  clr_bit  = served ? (NSRC'(1) << vec_id) : '0;
  wire             wr_req   = wr_en && wr_sel == 2'd0;
  wire             wr_msk   = wr_en && wr_sel == 2'd1;
  wire             wr_pri   = wr_en && wr_sel == 2'd2;

  assign irq_out = gie & (|pend);

  logic [3:0] gv, gb;
  always_comb begin
    gv = '0;
    gb = '0;
    for (int g = 0; g < NGRP; g++) begin
      gv[g] = pend[2*g] | pend[2*g+1];
      gb[g] = prio[3+g] ? pend[2*g+1] : ~pend[2*g];
    end
  end

  logic [5:0] ord;
  always_comb begin
    case (prio[2:0])
      3'd2:    ord = {2'd1, 2'd2, 2'd0};
      3'd3:    ord = {2'd2, 2'd0, 2'd1};
      3'd4:    ord = {2'd0, 2'd2, 2'd1};
      3'd5:    ord = {2'd1, 2'd0, 2'd2};
      3'd6:    ord = {2'd0, 2'd1, 2'd2};
      default: ord = {2'd2, 2'd1, 2'd0};
    endcase
  end

  always_comb begin
    vec_id = '0;
    for (int k = 2; k >= 0; k--) begin
      if (gv[ord[2*k +: 2]])
        vec_id = {ord[2*k +: 2], 1'b0} + {2'b00, gb[ord[2*k +: 2]]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1   <= '0;
      s2   <= '0;
      s2_d <= '0;
    end else begin
      s1   <= ext_req;
      s2   <= s1;
      s2_d <= s2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      gie   <= 1'b0;
      req_q <= '0;
      en    <= '0;
      prio  <= '0;
    end else begin
      if (gie_set) armed <= 1'b1;
      if (gie_clr || served) gie <= 1'b0;
      else if (gie_set)      gie <= 1'b1;
      else if (wr_msk)       gie <= wr_data[7];
      if (wr_msk) en   <= wr_data[NSRC-1:0];
      if (wr_pri) prio <= wr_data[5:0];
      if (!armed) req_q <= '0;
      else req_q <= ((wr_req ? wr_data[NSRC-1:0] : req_q) & ~clr_bit) | {tmr_req, ext_rise};
    end
  end
endmodule

module vec_irq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       armed,
  input logic [5:0] req_q,
  input logic       gie,
  input logic       irq_out,
  input logic [2:0] vec_id,
  input logic       ack,
  input logic       gie_set,
  input logic       gie_clr
);
  AST_LOCKED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> req_q == 6'd0); // R2
  AST_ACK_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq_out) |=> (!irq_out && !gie)); // R11
  AST_VEC_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> req_q[vec_id]); // R8
  AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    gie_clr |=> !gie); // R7
  AST_SET_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    (gie_set && !gie_clr && !(ack && irq_out)) |=> gie); // R7
endmodule

bind vec_irq_ctrl vec_irq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .armed(armed), .req_q(req_q), .gie(gie),
  .irq_out(irq_out), .vec_id(vec_id), .ack(ack), .gie_set(gie_set), .gie_clr(gie_clr)
);

// File: tb/tb_vec_irq_ctrl.sv
`timescale 1ns/1ps
module tb_vec_irq_ctrl;
  logic       clk = 0, rst_n = 0;
  logic [3:0] ext_req = 0;
  logic [1:0] tmr_req = 0;
  logic       wr_en = 0;
  logic [1:0] wr_sel = 3;
  logic [7:0] wr_data = 0;
  logic       gie_set = 0, gie_clr = 0, ack = 0;
  logic [5:0] req_q;
  logic       gie, irq_out;
  logic [2:0] vec_id;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  vec_irq_ctrl dut (.*);

  task automatic check(input string rq, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic cyc(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    wr_en = 1; wr_sel = sel; wr_data = d;
    cyc();
    wr_en = 0; wr_sel = 3;
  endtask

  task automatic pulse_set();
    gie_set = 1; cyc(); gie_set = 0;
  endtask

  function automatic logic [2:0] model_vec(input logic [5:0] p, input logic [5:0] pr);
    int ord[3];
    case (pr[2:0])
      3'd2: ord = '{0, 2, 1};
      3'd3: ord = '{1, 0, 2};
      3'd4: ord = '{1, 2, 0};
      3'd5: ord = '{2, 0, 1};
      3'd6: ord = '{2, 1, 0};
      default: ord = '{0, 1, 2};
    endcase
    for (int k = 0; k < 3; k++) begin
      int g = ord[k];
      if (p[2*g] || p[2*g+1]) begin
        if (pr[3+g]) return 3'(2*g + (p[2*g+1] ? 1 : 0));
        else         return 3'(2*g + (p[2*g] ? 0 : 1));
      end
    end
    return 3'd0;
  endfunction

  task automatic t_reset();
    check("R1 req", {2'b0, req_q}, 8'h00);
    check("R1 gie", {7'b0, gie}, 8'h00);
    check("R1 irq", {7'b0, irq_out}, 8'h00);
    check("R1 vec", {5'b0, vec_id}, 8'h00);
  endtask

  task automatic t_lock();
    wr(0, 8'h3F);
    check("R2 write ignored", {2'b0, req_q}, 8'h00);
    tmr_req = 2'b11; cyc(); tmr_req = 0;
    check("R2 timer ignored", {2'b0, req_q}, 8'h00);
    ext_req = 4'b0001; cyc(4); ext_req = 0; cyc(3);
    check("R2 ext ignored", {2'b0, req_q}, 8'h00);
    pulse_set();
    check("R7 gie set", {7'b0, gie}, 8'h01);
  endtask

  task automatic t_ext();
    ext_req[2] = 1;
    cyc(2);
    check("R3 not yet", {7'b0, req_q[2]}, 8'h00);
    cyc();
    check("R3 captured", {2'b0, req_q}, 8'h04);
    wr(0, 8'h00);
    cyc(3);
    check("R3 held line once", {2'b0, req_q}, 8'h00);
    ext_req = 0; cyc(3);
  endtask

  task automatic t_timer();
    tmr_req = 2'b10; cyc(); tmr_req = 0;
    check("R4 timer1", {2'b0, req_q}, 8'h20);
    tmr_req = 2'b01; cyc(); tmr_req = 0;
    check("R4 timer0", {2'b0, req_q}, 8'h30);
    wr(0, 8'h00);
  endtask

  task automatic t_sw();
    wr(0, 8'h2A);
    check("R5 sw load", {2'b0, req_q}, 8'h2A);
    wr_en = 1; wr_sel = 0; wr_data = 8'h01; tmr_req = 2'b01;
    cyc();
    wr_en = 0; wr_sel = 3; tmr_req = 0;
    check("R5 or with set", {2'b0, req_q}, 8'h11);
    wr(0, 8'h2A);
  endtask

  task automatic t_mask();
    wr(1, 8'h80);
    check("R6 all masked", {7'b0, irq_out}, 8'h00);
    wr(1, 8'h82);
    check("R6 one enabled", {7'b0, irq_out}, 8'h01);
    check("R6 vec", {5'b0, vec_id}, 8'h01);
    wr(1, 8'h02);
    check("R6 gie via mask", {7'b0, gie}, 8'h00);
    check("R6 irq off", {7'b0, irq_out}, 8'h00);
  endtask

  task automatic t_prio();
    logic [5:0] pats[8] = '{6'h3F, 6'h2A, 6'h15, 6'h30, 6'h0C, 6'h21, 6'h12, 6'h03};
    wr(1, 8'hBF);
    for (int pr = 0; pr < 64; pr++) begin
      wr(2, 8'(pr));
      for (int i = 0; i < 8; i++) begin
        wr(0, {2'b0, pats[i]});
        if (pr[2:0] == 0 || pr[2:0] == 7)
          check("R10 reserved order", {5'b0, vec_id}, {5'b0, model_vec(pats[i], 6'(pr))});
        else if (pr[5:3] != 0)
          check("R9 swap", {5'b0, vec_id}, {5'b0, model_vec(pats[i], 6'(pr))});
        else
          check("R8 group order", {5'b0, vec_id}, {5'b0, model_vec(pats[i], 6'(pr))});
      end
    end
  endtask

  task automatic t_gie();
    gie_set = 1; gie_clr = 1; cyc(); gie_set = 0; gie_clr = 0;
    check("R7 clr wins", {7'b0, gie}, 8'h00);
    pulse_set();
    gie_clr = 1; cyc(); gie_clr = 0;
    check("R7 clr", {7'b0, gie}, 8'h00);
  endtask

  task automatic t_ack();
    wr(2, 8'h01);
    wr(0, 8'h24);
    pulse_set();
    check("R11 vec before ack", {5'b0, vec_id}, 8'h02);
    ack = 1; cyc(); ack = 0;
    check("R11 bit cleared", {2'b0, req_q}, 8'h20);
    check("R11 gie cleared", {7'b0, gie}, 8'h00);
    check("R11 irq dropped", {7'b0, irq_out}, 8'h00);
    wr(0, 8'h24);
    ack = 1; cyc(); ack = 0;
    check("R11 idle ack", {2'b0, req_q}, 8'h24);
  endtask

  task automatic t_poll();
    wr(0, 8'h20);
    check("R12 poll visible", {2'b0, req_q}, 8'h20);
    check("R12 no irq", {7'b0, irq_out}, 8'h00);
  endtask

  initial begin
    #(200000 * 20);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    cyc(2);
    rst_n = 1;
    cyc();
    t_reset();
    t_lock();
    t_ext();
    t_timer();
    t_sw();
    t_mask();
    t_prio();
    t_gie();
    t_ack();
    t_poll();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule